// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Output-Register Reset

This block is a true dual-port RAM. Ports A and B each have their own clock, enable, write enable, synchronous output clear, address, write data and registered read data. Either port can read or write any word. All of a port's inputs are taken at that port's capture edge, and the port's data output changes just after that edge. A write is write-first: the writing port's output shows the word it has just stored.

A port's synchronous clear zeroes only that port's output register. The array keeps its contents, and a write request in the same cycle is dropped. Two kinds of collision give a defined invalid result, the poison word, which is a parameter that defaults to all-X. The first is both ports writing one word at the same edge. The second is one port reading a word that the other port writes at the same edge. The sense of each port's clock edge, enable, write enable and clear can be inverted by parameter. An asynchronous active-low reset, released through a two-flop synchronizer per port, clears both output registers. It leaves the stored words alone.

Top module: `dual_port_ram`

## Requirements
- R1: With enable active, write enable active and clear inactive at a capture edge, `din` is stored at `addr`, and the same port's `dout` shows `din` after that edge.
- R2: With enable active, write enable inactive and clear inactive, `dout` shows the word stored at `addr` after the edge. Words written by either port can be read by either port.
- R3: With enable and clear both active, that port's `dout` becomes 0 after the edge. The request is not a write, and stored words keep their values.
- R4: With enable inactive, the port's `dout` holds its value and no write occurs, whatever the other inputs are.
- R5: Bit 0 of `EN_NEG`, `WE_NEG` and `SRST_NEG` makes the matching port A signal active-low, and bit 1 does the same for port B. A set bit of `CLK_NEG` makes the falling edge that port's capture edge, and the rising edge then has no effect.
- R6: When both ports write the same address at the same edge, both outputs show `POISON` after the edge, and later reads of that word return `POISON`.
- R7: When one port reads an address that the other port writes at the same edge, the reader's `dout` shows `POISON`. The writer's output and the stored word take the written data.
- R8: Writes from the two ports to different addresses at the same edge both take effect.
- R9: Driving `rst_n` low clears both outputs at once, without waiting for a clock. Release is synchronized to each port's capture clock, and stored words survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| srst_a | input | 1 | Port A synchronous output clear |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| srst_b | input | 1 | Port B synchronous output clear |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B registered read data |

## Verification
The collision cases are the hardest to reach, because both ports must present matching addresses at exactly the same capture edge. The bench therefore drives both ports from one clock. Each scoreboard step sets both request sets at the same falling edge, so a double write or a read-against-write lands on a single rising edge. The poison word is overridden to a visible constant because a two-state simulator would turn X into an ordinary value. The bench then reads the word back to show it stays poisoned after a double write and keeps the writer's data after a read-against-write.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD   = 3'd0,
    SEL_CLEAR  = 3'd1,
    SEL_WDATA  = 3'd2,
    SEL_READ   = 3'd3,
    SEL_POISON = 3'd4
  } out_sel_t;

  localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpram_rst_sync.sv
`timescale 1ns/1ps
module dpram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dpram_decode.sv
`timescale 1ns/1ps
module dpram_decode #(
  parameter bit EN_NEG   = 1'b0,
  parameter bit WE_NEG   = 1'b0,
  parameter bit SRST_NEG = 1'b0
) (
  input  logic en_pin,
  input  logic we_pin,
  input  logic srst_pin,
  output logic en_on,
  output logic wr_go,
  output logic rd_go,
  output logic clr_go
);
  logic en_l;
  logic we_l;
  logic clr_l;

  assign en_l  = en_pin   ^ EN_NEG;
  assign we_l  = we_pin   ^ WE_NEG;
  assign clr_l = srst_pin ^ SRST_NEG;

  assign en_on  = en_l;
  assign wr_go  = en_l & ~clr_l & we_l;
  assign rd_go  = en_l & ~clr_l & ~we_l;
  assign clr_go = en_l & clr_l;
endmodule

// File: rtl/dpram_bank.sv
`timescale 1ns/1ps
module dpram_bank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                               clk,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  waddr,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic [dpram_pkg::NUM_PORTS-1:0][ADDR_W-1:0] raddr,
  output logic [dpram_pkg::NUM_PORTS-1:0][DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  for (genvar r = 0; r < dpram_pkg::NUM_PORTS; r++) begin : g_rd
    assign rdata[r] = cells[raddr[r]];
  end
endmodule

// File: rtl/dpram_outreg.sv
`timescale 1ns/1ps
module dpram_outreg
  import dpram_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] POISON = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  out_sel_t          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] nxt;
  logic              load;

  always_comb begin
    nxt  = q;
    load = 1'b1;
    case (sel)
      SEL_CLEAR:  nxt = '0;
      SEL_WDATA:  nxt = wdata;
      SEL_READ:   nxt = rdata;
      SEL_POISON: nxt = POISON;
      default:    load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= nxt;
  end

  assign dout = q;
endmodule

// File: rtl/dual_port_ram.sv
`timescale 1ns/1ps
module dual_port_ram
  import dpram_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter int                DATA_W   = 16,
  parameter bit [1:0]          CLK_NEG  = 2'b00,
  parameter bit [1:0]          EN_NEG   = 2'b00,
  parameter bit [1:0]          WE_NEG   = 2'b00,
  parameter bit [1:0]          SRST_NEG = 2'b00,
  parameter logic [DATA_W-1:0] POISON   = 'x
) (
  input  logic              rst_n,
  input  logic              clk_a,
  input  logic              en_a,
  input  logic              we_a,
  input  logic              srst_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [DATA_W-1:0] dout_a,
  input  logic              clk_b,
  input  logic              en_b,
  input  logic              we_b,
  input  logic              srst_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] dout_b
);
  localparam int NP = NUM_PORTS;

  logic [NP-1:0]             clk_raw, en_raw, we_raw, clr_raw;
  logic [NP-1:0]             cap_clk, rst_ok;
  logic [NP-1:0]             act_en, wr, rd, srst;
  logic [NP-1:0][ADDR_W-1:0] addr;
  logic [NP-1:0][DATA_W-1:0] din, dout;
  // bank_rd[bank][port]: bank contents at each port's address
  logic [NP-1:0][NP-1:0][DATA_W-1:0] bank_rd;
  logic                      same_addr;
  logic                      dbl_wr;

  assign clk_raw = {clk_b, clk_a};
  assign en_raw  = {en_b, en_a};
  assign we_raw  = {we_b, we_a};
  assign clr_raw = {srst_b, srst_a};
  assign addr    = {addr_b, addr_a};
  assign din     = {din_b, din_a};

  assign same_addr = (addr[0] == addr[1]);
  assign dbl_wr    = wr[0] & wr[1] & same_addr;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int Q     = NP - 1 - p;
    localparam bit DEFER = (p == 1);

    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] other;
    logic [DATA_W-1:0] bank_wdata;
    logic              bank_we;
    out_sel_t          sel;

    assign cap_clk[p] = clk_raw[p] ^ CLK_NEG[p];

    dpram_rst_sync u_rsync (
      .clk        (cap_clk[p]),
      .rst_n      (rst_n),
      .rst_n_sync (rst_ok[p])
    );

    dpram_decode #(
      .EN_NEG   (EN_NEG[p]),
      .WE_NEG   (WE_NEG[p]),
      .SRST_NEG (SRST_NEG[p])
    ) u_dec (
      .en_pin   (en_raw[p]),
      .we_pin   (we_raw[p]),
      .srst_pin (clr_raw[p]),
      .en_on    (act_en[p]),
      .wr_go    (wr[p]),
      .rd_go    (rd[p]),
      .clr_go   (srst[p])
    );

    // word value is the XOR of both banks; each bank has a single writer
    assign stored     = bank_rd[0][p] ^ bank_rd[1][p];
    assign other      = bank_rd[Q][p];
    assign bank_we    = wr[p] & ~(dbl_wr & DEFER);
    assign bank_wdata = (dbl_wr ? POISON : din[p]) ^ other;

    always_comb begin
      if (srst[p])                           sel = SEL_CLEAR;
      else if (dbl_wr)                       sel = SEL_POISON;
      else if (wr[p])                        sel = SEL_WDATA;
      else if (rd[p] && wr[Q] && same_addr)  sel = SEL_POISON;
      else if (rd[p])                        sel = SEL_READ;
      else                                   sel = SEL_HOLD;
    end

    dpram_bank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_bank (
      .clk   (cap_clk[p]),
      .we    (bank_we),
      .waddr (addr[p]),
      .wdata (bank_wdata),
      .raddr (addr),
      .rdata (bank_rd[p])
    );

    dpram_outreg #(
      .DATA_W (DATA_W),
      .POISON (POISON)
    ) u_out (
      .clk   (cap_clk[p]),
      .rst_n (rst_ok[p]),
      .sel   (sel),
      .wdata (din[p]),
      .rdata (stored),
      .dout  (dout[p])
    );
  end

  assign dout_a = dout[0];
  assign dout_b = dout[1];
endmodule

// File: rtl/dpram_chk.sv
`timescale 1ns/1ps
module dpram_chk #(
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] POISON = '0
) (
  input logic [1:0]        cap_clk,
  input logic [1:0]        rst_ok,
  input logic [1:0]        act_en,
  input logic [1:0]        wr,
  input logic [1:0]        rd,
  input logic [1:0]        srst,
  input logic              same_addr,
  input logic              dbl_wr,
  input logic [DATA_W-1:0] din_a,
  input logic [DATA_W-1:0] din_b,
  input logic [DATA_W-1:0] dout_a,
  input logic [DATA_W-1:0] dout_b
);
  AST_WRITE_FIRST_A: assert property (@(posedge cap_clk[0]) disable iff (!rst_ok[0]) (wr[0] && !dbl_wr) |=> (dout_a === $past(din_a))); // R1
  AST_WRITE_FIRST_B: assert property (@(posedge cap_clk[1]) disable iff (!rst_ok[1]) (wr[1] && !dbl_wr) |=> (dout_b === $past(din_b))); // R1
  AST_CLEAR_OUT_A: assert property (@(posedge cap_clk[0]) disable iff (!rst_ok[0]) srst[0] |=> (dout_a == '0)); // R3
  AST_HOLD_IDLE_A: assert property (@(posedge cap_clk[0]) disable iff (!rst_ok[0]) !act_en[0] |=> $stable(dout_a)); // R4
  AST_DOUBLE_WRITE_A: assert property (@(posedge cap_clk[0]) disable iff (!rst_ok[0]) dbl_wr |=> (dout_a === POISON)); // R6
  AST_DOUBLE_WRITE_B: assert property (@(posedge cap_clk[1]) disable iff (!rst_ok[1]) dbl_wr |=> (dout_b === POISON)); // R6
  AST_READ_COLLIDE_A: assert property (@(posedge cap_clk[0]) disable iff (!rst_ok[0]) (rd[0] && wr[1] && same_addr) |=> (dout_a === POISON)); // R7
  AST_READ_COLLIDE_B: assert property (@(posedge cap_clk[1]) disable iff (!rst_ok[1]) (rd[1] && wr[0] && same_addr) |=> (dout_b === POISON)); // R7
endmodule

bind dual_port_ram dpram_chk #(
  .DATA_W (DATA_W),
  .POISON (POISON)
) u_chk (
  .cap_clk   (cap_clk),
  .rst_ok    (rst_ok),
  .act_en    (act_en),
  .wr        (wr),
  .rd        (rd),
  .srst      (srst),
  .same_addr (same_addr),
  .dbl_wr    (dbl_wr),
  .din_a     (din_a),
  .din_b     (din_b),
  .dout_a    (dout_a),
  .dout_b    (dout_b)
);

// File: tb/dual_port_ram_test.sv
`timescale 1ns/1ps
module dual_port_ram_test;
  localparam logic [15:0] PZN = 16'hBAD1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b1;
  // port A active-high controls; port B logical values (inverted at the pins)
  logic a_en = 0, a_we = 0, a_sr = 0; logic [3:0] a_ad = 0; logic [15:0] a_di = 0;
  logic b_en = 0, b_we = 0, b_sr = 0; logic [3:0] b_ad = 0; logic [15:0] b_di = 0;
  logic [15:0] dout_a, dout_b;

  dual_port_ram #(
    .ADDR_W(4), .DATA_W(16), .CLK_NEG(2'b00), .EN_NEG(2'b10),
    .WE_NEG(2'b10), .SRST_NEG(2'b10), .POISON(PZN)
  ) uut (
    .rst_n(rst_n),
    .clk_a(clk), .en_a(a_en), .we_a(a_we), .srst_a(a_sr), .addr_a(a_ad), .din_a(a_di), .dout_a(dout_a),
    .clk_b(clk), .en_b(~b_en), .we_b(~b_we), .srst_b(~b_sr), .addr_b(b_ad), .din_b(b_di), .dout_b(dout_b)
  );

  // falling-edge instance for the clock polarity option
  logic f_ena = 0, f_wea = 0, f_enb = 0;
  logic [3:0] f_ad = 0; logic [15:0] f_di = 0;
  logic [15:0] fo_a, fo_b;

  dual_port_ram #(
    .ADDR_W(4), .DATA_W(16), .CLK_NEG(2'b11), .POISON(PZN)
  ) uut_f (
    .rst_n(rst_n),
    .clk_a(clk), .en_a(f_ena), .we_a(f_wea), .srst_a(1'b0), .addr_a(f_ad), .din_a(f_di), .dout_a(fo_a),
    .clk_b(clk), .en_b(f_enb), .we_b(1'b0), .srst_b(1'b0), .addr_b(f_ad), .din_b(16'h0), .dout_b(fo_b)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] qa[$];
  logic [15:0] qb[$];
  string       qt[$];

  logic [15:0] mdl[16];
  logic [15:0] ea = 0, eb = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: drive both ports, update the model, push the expected outputs
  task automatic step(input logic ien, iwe, isr, input logic [3:0] iad, input logic [15:0] idi,
                      input logic jen, jwe, jsr, input logic [3:0] jad, input logic [15:0] jdi,
                      input string tag);
    logic wa, wb, ra, rb, dw;
    @(negedge clk);
    a_en = ien; a_we = iwe; a_sr = isr; a_ad = iad; a_di = idi;
    b_en = jen; b_we = jwe; b_sr = jsr; b_ad = jad; b_di = jdi;
    wa = ien & ~isr & iwe;  ra = ien & ~isr & ~iwe;
    wb = jen & ~jsr & jwe;  rb = jen & ~jsr & ~jwe;
    dw = wa & wb & (iad == jad);
    if (ien & isr)                ea = 16'h0;
    else if (dw)                  ea = PZN;
    else if (wa)                  ea = idi;
    else if (ra & wb & (iad == jad)) ea = PZN;
    else if (ra)                  ea = mdl[iad];
    if (jen & jsr)                eb = 16'h0;
    else if (dw)                  eb = PZN;
    else if (wb)                  eb = jdi;
    else if (rb & wa & (iad == jad)) eb = PZN;
    else if (rb)                  eb = mdl[jad];
    if (dw) mdl[iad] = PZN;
    else begin
      if (wa) mdl[iad] = idi;
      if (wb) mdl[jad] = jdi;
    end
    qa.push_back(ea); qb.push_back(eb); qt.push_back(tag);
  endtask

  // monitor: compare one expectation after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    if (qt.size() > 0) begin
      string t;
      logic [15:0] xa, xb;
      t = qt.pop_front(); xa = qa.pop_front(); xb = qb.pop_front();
      chk({t, " port A"}, dout_a, xa);
      chk({t, " port B"}, dout_b, xb);
    end
  end

  task automatic drain();
    while (qt.size() > 0) @(posedge clk);
    #2;
  endtask

  initial begin
    #2 rst_n = 1'b0;
    #1;
    chk("R9 reset A", dout_a, 16'h0);
    chk("R9 reset B", dout_b, 16'h0);
    #10 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    step(1,1,0,4'd1,16'h1111, 0,0,0,4'd0,16'h0,    "R1");
    step(0,0,0,4'd0,16'h0,    1,1,0,4'd2,16'h2222, "R1");
    step(1,0,0,4'd2,16'h0,    1,0,0,4'd1,16'h0,    "R2");
    step(1,1,0,4'd3,16'h3333, 1,1,0,4'd4,16'h4444, "R8");
    step(1,0,0,4'd4,16'h0,    1,0,0,4'd3,16'h0,    "R8");
    step(1,1,1,4'd3,16'hFFFF, 1,0,0,4'd3,16'h0,    "R3");
    step(1,0,0,4'd3,16'h0,    0,0,0,4'd0,16'h0,    "R3");
    step(0,1,0,4'd4,16'h9999, 0,1,0,4'd4,16'h8888, "R4");
    step(1,0,0,4'd4,16'h0,    0,0,0,4'd0,16'h0,    "R4");
    step(0,0,0,4'd0,16'h0,    1,0,1,4'd1,16'h0,    "R5");
    step(1,1,0,4'd5,16'hAAAA, 1,1,0,4'd5,16'h5555, "R6");
    step(1,0,0,4'd5,16'h0,    1,0,0,4'd5,16'h0,    "R6");
    step(1,1,0,4'd6,16'h6060, 0,0,0,4'd0,16'h0,    "R1");
    step(1,0,0,4'd6,16'h0,    1,1,0,4'd6,16'h0606, "R7");
    step(1,0,0,4'd6,16'h0,    0,0,0,4'd0,16'h0,    "R7");
    step(1,1,0,4'd7,16'h7777, 1,0,0,4'd7,16'h0,    "R7");
    step(0,0,0,4'd0,16'h0,    1,0,0,4'd7,16'h0,    "R7");
    step(0,0,0,4'd0,16'h0,    0,0,0,4'd0,16'h0,    "R4");
    drain();

    // asynchronous reset mid-run, contents must survive
    rst_n = 1'b0;
    #1;
    chk("R9 async clear A", dout_a, 16'h0);
    chk("R9 async clear B", dout_b, 16'h0);
    ea = 16'h0; eb = 16'h0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    step(1,0,0,4'd1,16'h0,    1,0,0,4'd2,16'h0,    "R9");
    step(0,0,0,4'd0,16'h0,    0,0,0,4'd0,16'h0,    "R9");
    drain();

    // falling-edge capture instance
    @(posedge clk); #1;
    f_ena = 1; f_wea = 1; f_ad = 4'd9; f_di = 16'h1234;
    #0.5;
    chk("R5 no rising capture", fo_a, 16'h0);
    @(negedge clk); #1;
    chk("R5 falling write", fo_a, 16'h1234);
    @(posedge clk); #1;
    f_ena = 0; f_wea = 0; f_enb = 1;
    @(negedge clk); #1;
    chk("R5 falling read", fo_b, 16'h1234);
    f_enb = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule